// File: doc/BRIEF.md
# Accumulator Processor with Combined Microoperation Instruction

This block is a small stored-program machine built around one accumulator. It holds a program counter, an accumulator, an auxiliary register and a single word-addressed memory in which code and data live side by side. Before a run, the memory is filled through a load port. A pulse on `start` then sets the machine fetching, decoding and executing one instruction after another until it meets a jump to its own address. At that point it parks in a halted state and raises `halted`.

Each instruction word is 14 bits wide. Bits [13:11] carry the opcode, bits [10:3] carry the address field and bits [2:0] carry three flags. Data words are 8 bits wide, sit in the low bits of a memory word and wrap on overflow. When the machine writes data into memory, it clears the upper six bits of that word. Five opcodes do work:
- add memory into the accumulator
- store the accumulator and then clear it
- increment memory and skip when the result is zero
- jump
- a microoperation word whose flags run in a fixed order: increment the accumulator, then skip on a zero accumulator, then exchange it with the auxiliary register.

The controller is a state machine with six states:
- IDLE: waits for `start`; the load port is open.
- FETCH: presents PC to the memory.
- LATCH: captures the instruction word.
- OPND: presents the address field to the memory.
- EXEC: applies the instruction and performs any memory write.
- HALT: terminal state.

It has seven transitions:
- IDLE to FETCH on `start`.
- IDLE to IDLE otherwise.
- FETCH to LATCH.
- LATCH to OPND.
- OPND to EXEC.
- EXEC to HALT on a self-jump.
- EXEC to FETCH otherwise.

HALT is left only by reset.

Top module: `acc_cpu`

## Requirements
- R1: After reset, PC, AC and AX are 0, `halted` is 0 and the machine is idle.
- R2: A load-port write (`load_en` high at a clock edge) stores `load_word` at `load_addr` only while the machine is idle. While a program runs, `load_en` is ignored and memory keeps its contents.
- R3: Opcode 0 adds the low 8 bits of M[A] into AC, modulo 256, and PC advances by one.
- R4: Opcode 1 writes AC (zero-extended) to M[A] and then sets AC to 0. PC advances by one.
- R5: Opcode 2 writes M[A]+1 (8-bit, wrapping) back to M[A]. When that result is 0, PC advances by two; otherwise it advances by one.
- R6: Opcode 3 loads PC with A. When A equals the current PC, the machine enters HALT, holds `halted` high and keeps PC unchanged until reset.
- R7: Opcode 7 with flag bit 0 set increments AC by one, modulo 256.
- R8: Opcode 7 with flag bit 1 set skips the next word (PC advances by two) when AC is zero. AC here is taken after any bit-0 increment in the same instruction.
- R9: Opcode 7 with flag bit 2 set exchanges AC and AX. The value moved into AX is AC after any bit-0 increment.
- R10: Opcode 7 with all flags clear, and opcodes 4, 5 and 6, leave AC, AX and memory unchanged and advance PC by one.
- R11: Every instruction takes four clock cycles (FETCH, LATCH, OPND, EXEC). A `start` pulse sampled in IDLE reaches HALT eight edges later for a two-instruction program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins execution from PC when idle |
| load_en | input | 1 | Memory write strobe for the load port |
| load_addr | input | 8 | Load port word address |
| load_word | input | 14 | Load port word to store |
| halted | output | 1 | High once a self-jump has executed |
| pc_o | output | 8 | Current program counter |
| ac_o | output | 8 | Current accumulator |
| ax_o | output | 8 | Current auxiliary register |

## Verification
The bench aims at the ordering inside the microoperation word: an increment that turns 255 into 0 must trigger the zero skip. A design that tests AC before the increment would run the skipped word and finish with a different accumulator. The swap must carry the incremented value, so one that exchanges first leaves the stale value in AX. The increment-and-skip wrap from 255 and the store-then-clear sequence are read back through later adds, so a missing skip or a missing clear shows up as a wrong sum. A load strobe during a run and the exact four-cycle instruction pace are also probed, catching a memory that accepts writes while busy or a controller with a missing or extra state.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OP_W   = 3;
    localparam int FLAG_W = 3;

    localparam logic [OP_W-1:0] OPC_ADD = 3'd0;
    localparam logic [OP_W-1:0] OPC_STC = 3'd1;
    localparam logic [OP_W-1:0] OPC_ISZ = 3'd2;
    localparam logic [OP_W-1:0] OPC_JMP = 3'd3;
    localparam logic [OP_W-1:0] OPC_MIC = 3'd7;

    localparam int FLG_INC = 0;
    localparam int FLG_SKZ = 1;
    localparam int FLG_SWP = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LATCH,
        ST_OPND,
        ST_EXEC,
        ST_HALT
    } cpu_state_t;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        rdata <= store[addr];
    end

endmodule

// File: rtl/acc_cpu_fsm.sv
module acc_cpu_fsm
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       self_jump,
    output cpu_state_t state,
    output logic       latch_ir,
    output logic       exec_en,
    output logic       idle,
    output logic       halted
);
    cpu_state_t state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  state_n = start ? ST_FETCH : ST_IDLE;
            ST_FETCH: state_n = ST_LATCH;
            ST_LATCH: state_n = ST_OPND;
            ST_OPND:  state_n = ST_EXEC;
            ST_EXEC:  state_n = self_jump ? ST_HALT : ST_FETCH;
            ST_HALT:  state_n = ST_HALT;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        latch_ir = 1'b0;
        exec_en  = 1'b0;
        idle     = 1'b0;
        halted   = 1'b0;
        unique case (state)
            ST_IDLE:  idle     = 1'b1;
            ST_LATCH: latch_ir = 1'b1;
            ST_EXEC:  exec_en  = 1'b1;
            ST_HALT:  halted   = 1'b1;
            default:  ;
        endcase
    end

    // R6: the halt state is never left without reset
    p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT));

    // R11: the fetch is followed by the instruction latch
    p_fetch_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_LATCH));

    // R11: execution ends in a new fetch or in halt
    p_exec_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |=> (state == ST_FETCH || state == ST_HALT));

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             latch_ir,
    input  logic                             exec_en,
    input  logic [OP_W+ADDR_W+FLAG_W-1:0]    rdata,
    output logic [ADDR_W-1:0]                pc,
    output logic [DATA_W-1:0]                ac,
    output logic [DATA_W-1:0]                ax,
    output logic [ADDR_W-1:0]                opnd_addr,
    output logic                             self_jump,
    output logic                             wr_en,
    output logic [OP_W+ADDR_W+FLAG_W-1:0]    wr_data
);
    localparam int INSN_W = OP_W + ADDR_W + FLAG_W;

    logic [INSN_W-1:0] ir;
    logic [OP_W-1:0]   op;
    logic [FLAG_W-1:0] fl;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] bump;
    logic [DATA_W-1:0] tmp;
    logic              skip;
    logic              wr_req;
    logic [ADDR_W-1:0] pc_n;
    logic [DATA_W-1:0] ac_n;
    logic [DATA_W-1:0] ax_n;

    assign op        = ir[INSN_W-1 -: OP_W];
    assign opnd_addr = ir[FLAG_W +: ADDR_W];
    assign fl        = ir[FLAG_W-1:0];
    assign operand   = rdata[DATA_W-1:0];
    assign bump      = operand + DATA_W'(1);
    assign self_jump = exec_en && (op == OPC_JMP) && (opnd_addr == pc);
    assign wr_en     = exec_en && wr_req;

    always_comb begin
        ac_n    = ac;
        ax_n    = ax;
        tmp     = ac;
        skip    = 1'b0;
        wr_req  = 1'b0;
        wr_data = '0;
        case (op)
            OPC_ADD: ac_n = ac + operand;
            OPC_STC: begin
                wr_req  = 1'b1;
                wr_data = INSN_W'(ac);
                ac_n    = '0;
            end
            OPC_ISZ: begin
                wr_req  = 1'b1;
                wr_data = INSN_W'(bump);
                skip    = (bump == '0);
            end
            OPC_MIC: begin
                tmp  = ac + DATA_W'(fl[FLG_INC]);
                skip = fl[FLG_SKZ] && (tmp == '0);
                if (fl[FLG_SWP]) begin
                    ac_n = ax;
                    ax_n = tmp;
                end else begin
                    ac_n = tmp;
                end
            end
            default: ;
        endcase
        if (op == OPC_JMP) begin
            pc_n = opnd_addr;
        end else begin
            pc_n = pc + ADDR_W'(1) + ADDR_W'(skip);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir <= '0;
            pc <= '0;
            ac <= '0;
            ax <= '0;
        end else begin
            if (latch_ir) begin
                ir <= rdata;
            end
            if (exec_en) begin
                pc <= pc_n;
                ac <= ac_n;
                ax <= ax_n;
            end
        end
    end

    // R4: the accumulator reads zero right after a store
    p_store_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OPC_STC) |=> (ac == '0));

    // R5: incrementing an all-ones word steps PC by two
    p_skip_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OPC_ISZ && (&operand)) |=> (pc == $past(pc) + ADDR_W'(2)));

    // R9: the exchange moves the post-increment accumulator into AX
    p_swap_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == OPC_MIC && fl[FLG_SWP]) |=>
        (ax == $past(ac) + DATA_W'($past(fl[FLG_INC])) && ac == $past(ax)));

    // R10: unassigned opcodes keep both data registers
    p_nop_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (op == 3'd4 || op == 3'd5 || op == 3'd6)) |=>
        (ac == $past(ac) && ax == $past(ax) && pc == $past(pc) + ADDR_W'(1)));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int INSN_W = OP_W + ADDR_W + FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [INSN_W-1:0] load_word,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] ac_o,
    output logic [DATA_W-1:0] ax_o
);
    cpu_state_t        state;
    logic              latch_ir;
    logic              exec_en;
    logic              idle;
    logic              self_jump;
    logic [ADDR_W-1:0] opnd_addr;
    logic              dp_we;
    logic [INSN_W-1:0] dp_wdata;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [INSN_W-1:0] mem_wdata;
    logic [INSN_W-1:0] mem_rdata;

    acc_cpu_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .self_jump(self_jump),
        .state    (state),
        .latch_ir (latch_ir),
        .exec_en  (exec_en),
        .idle     (idle),
        .halted   (halted)
    );

    acc_cpu_dp #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_ir (latch_ir),
        .exec_en  (exec_en),
        .rdata    (mem_rdata),
        .pc       (pc_o),
        .ac       (ac_o),
        .ax       (ax_o),
        .opnd_addr(opnd_addr),
        .self_jump(self_jump),
        .wr_en    (dp_we),
        .wr_data  (dp_wdata)
    );

    always_comb begin
        case (state)
            ST_FETCH:         mem_addr = pc_o;
            ST_OPND, ST_EXEC: mem_addr = opnd_addr;
            default:          mem_addr = load_addr;
        endcase
    end

    assign mem_we    = dp_we || (idle && load_en);
    assign mem_wdata = dp_we ? dp_wdata : load_word;

    acc_cpu_mem #(
        .ADDR_W(ADDR_W),
        .WORD_W(INSN_W)
    ) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .addr (mem_addr),
        .wdata(mem_wdata),
        .rdata(mem_rdata)
    );

    // R2: outside idle, only the executing instruction writes memory
    p_load_idle_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !idle) |-> dp_we);

    // R6: PC stays put once halted
    p_pc_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_o));

endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic        load_en;
    logic [7:0]  load_addr;
    logic [13:0] load_word;
    logic        halted;
    logic [7:0]  pc_o;
    logic [7:0]  ac_o;
    logic [7:0]  ax_o;

    int checks;
    int failures;

    acc_cpu uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load_en  (load_en),
        .load_addr(load_addr),
        .load_word(load_word),
        .halted   (halted),
        .pc_o     (pc_o),
        .ac_o     (ac_o),
        .ax_o     (ax_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic logic [13:0] enc(input logic [2:0] op, input logic [7:0] a,
                                        input logic [2:0] f);
        return {op, a, f};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        load_en = 1'b0;
        load_addr = '0;
        load_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load(input logic [7:0] a, input logic [13:0] w);
        @(negedge clk);
        load_en = 1'b1;
        load_addr = a;
        load_word = w;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 3000; i++) begin
            if (halted) break;
            @(negedge clk);
        end
        check(halted == 1'b1, "R6 halt reached", int'(halted), 1);
    endtask

    task automatic run();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_halt();
    endtask

    task automatic t_reset();
        do_reset();
        check(pc_o == 8'd0, "R1 pc", pc_o, 0);
        check(ac_o == 8'd0, "R1 ac", ac_o, 0);
        check(ax_o == 8'd0, "R1 ax", ax_o, 0);
        check(halted == 1'b0, "R1 halted", int'(halted), 0);
    endtask

    task automatic t_add();
        do_reset();
        load(8'd100, 14'd200);
        load(8'd101, 14'd100);
        load(8'd0, enc(3'd0, 8'd100, 3'd0));
        load(8'd1, enc(3'd0, 8'd101, 3'd0));
        load(8'd2, enc(3'd3, 8'd2, 3'd0));
        run();
        check(ac_o == 8'd44, "R3 add wraps", ac_o, 44);
        check(pc_o == 8'd2, "R6 pc at self jump", pc_o, 2);
    endtask

    task automatic t_store();
        do_reset();
        load(8'd100, 14'd5);
        load(8'd0, enc(3'd0, 8'd100, 3'd0));
        load(8'd1, enc(3'd1, 8'd110, 3'd0));
        load(8'd2, enc(3'd0, 8'd110, 3'd0));
        load(8'd3, enc(3'd0, 8'd110, 3'd0));
        load(8'd4, enc(3'd3, 8'd4, 3'd0));
        run();
        check(ac_o == 8'd10, "R4 store then clear", ac_o, 10);
    endtask

    task automatic t_isz();
        do_reset();
        load(8'd100, 14'd7);
        load(8'd120, 14'd255);
        load(8'd121, 14'd3);
        load(8'd0, enc(3'd2, 8'd120, 3'd0));
        load(8'd1, enc(3'd0, 8'd100, 3'd0));
        load(8'd2, enc(3'd2, 8'd121, 3'd0));
        load(8'd3, enc(3'd0, 8'd121, 3'd0));
        load(8'd4, enc(3'd0, 8'd120, 3'd0));
        load(8'd5, enc(3'd3, 8'd5, 3'd0));
        run();
        check(ac_o == 8'd4, "R5 increment and skip", ac_o, 4);
        check(pc_o == 8'd5, "R5 final pc", pc_o, 5);
    endtask

    task automatic t_inc();
        do_reset();
        load(8'd0, enc(3'd7, 8'd0, 3'b001));
        load(8'd1, enc(3'd7, 8'd0, 3'b001));
        load(8'd2, enc(3'd3, 8'd2, 3'd0));
        run();
        check(ac_o == 8'd2, "R7 increment ac", ac_o, 2);
    endtask

    task automatic t_skz();
        do_reset();
        load(8'd100, 14'd255);
        load(8'd0, enc(3'd0, 8'd100, 3'd0));
        load(8'd1, enc(3'd7, 8'd0, 3'b011));
        load(8'd2, enc(3'd7, 8'd0, 3'b001));
        load(8'd3, enc(3'd7, 8'd0, 3'b010));
        load(8'd4, enc(3'd0, 8'd100, 3'd0));
        load(8'd5, enc(3'd7, 8'd0, 3'b001));
        load(8'd6, enc(3'd7, 8'd0, 3'b010));
        load(8'd7, enc(3'd7, 8'd0, 3'b001));
        load(8'd8, enc(3'd3, 8'd8, 3'd0));
        run();
        check(ac_o == 8'd2, "R8 zero skip after increment", ac_o, 2);
        check(pc_o == 8'd8, "R8 final pc", pc_o, 8);
    endtask

    task automatic t_swap();
        do_reset();
        load(8'd100, 14'd9);
        load(8'd0, enc(3'd0, 8'd100, 3'd0));
        load(8'd1, enc(3'd7, 8'd0, 3'b100));
        load(8'd2, enc(3'd7, 8'd0, 3'b001));
        load(8'd3, enc(3'd7, 8'd0, 3'b101));
        load(8'd4, enc(3'd3, 8'd4, 3'd0));
        run();
        check(ac_o == 8'd9, "R9 swap ac", ac_o, 9);
        check(ax_o == 8'd2, "R9 swap ax after increment", ax_o, 2);
    endtask

    task automatic t_nop();
        do_reset();
        load(8'd100, 14'd6);
        load(8'd0, enc(3'd0, 8'd100, 3'd0));
        load(8'd1, enc(3'd7, 8'd100, 3'b000));
        load(8'd2, enc(3'd4, 8'd100, 3'b111));
        load(8'd3, enc(3'd5, 8'd100, 3'b111));
        load(8'd4, enc(3'd6, 8'd100, 3'b111));
        load(8'd5, enc(3'd0, 8'd100, 3'd0));
        load(8'd6, enc(3'd3, 8'd6, 3'd0));
        run();
        check(ac_o == 8'd12, "R10 no-op keeps ac and memory", ac_o, 12);
        check(ax_o == 8'd0, "R10 no-op keeps ax", ax_o, 0);
        check(pc_o == 8'd6, "R10 pc steps by one", pc_o, 6);
    endtask

    task automatic t_jump_halt();
        logic [7:0] pc_hold;
        do_reset();
        load(8'd0, enc(3'd3, 8'd5, 3'd0));
        load(8'd1, enc(3'd7, 8'd0, 3'b001));
        load(8'd5, enc(3'd7, 8'd0, 3'b001));
        load(8'd6, enc(3'd3, 8'd6, 3'd0));
        run();
        check(ac_o == 8'd1, "R6 jump target executed", ac_o, 1);
        pc_hold = pc_o;
        repeat (20) @(negedge clk);
        check(pc_o == pc_hold && pc_o == 8'd6, "R6 pc frozen in halt", pc_o, 6);
        check(halted == 1'b1, "R6 halted held", int'(halted), 1);
    endtask

    task automatic t_timing();
        int n;
        do_reset();
        load(8'd0, enc(3'd7, 8'd0, 3'b001));
        load(8'd1, enc(3'd3, 8'd1, 3'd0));
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        for (int i = 0; i < 50; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (halted) break;
        end
        check(n == 8, "R11 four cycles per instruction", n, 8);
    endtask

    task automatic t_load_busy();
        do_reset();
        load(8'd100, 14'd3);
        load(8'd0, enc(3'd0, 8'd100, 3'd0));
        load(8'd1, enc(3'd0, 8'd100, 3'd0));
        load(8'd2, enc(3'd3, 8'd2, 3'd0));
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        load_en = 1'b1;
        load_addr = 8'd100;
        load_word = 14'd50;
        @(negedge clk);
        load_en = 1'b0;
        wait_halt();
        check(ac_o == 8'd6, "R2 load ignored while running", ac_o, 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        checks = 0;
        failures = 0;
        t_reset();
        t_add();
        t_store();
        t_isz();
        t_inc();
        t_skz();
        t_swap();
        t_nop();
        t_jump_halt();
        t_timing();
        t_load_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule